// File: doc/BRIEF.md
# Sleep Wake Source Interrupt Controller

This block holds the sleep/wake state of a motion-sensing front end. It also gates four event interrupts: transient, orientation, pulse and freefall/motion. An inactivity timer asks for sleep by pulsing a request input while the system is awake. While the system sleeps, only the sources whose wake-enable bit is set in an 8-bit control register can bring it back to wake. Sources that are not enabled are bypassed completely during sleep. While the system is awake, every source passes through whatever its enable bit holds.

The passed events drive two interrupt pins. A parameter sets the fixed route from sources to pins. One control bit sets the asserted level of both pins. Another control bit selects push-pull or open-drain drive. In open-drain mode, each pin comes with an output enable. The pin is driven only at its asserted level and is released otherwise.

Top module: `sleep_wake_irq_ctrl`

## Requirements
- R1: After reset the control register reads 8'h00, awake_o is 1, and both pins are deasserted and driven (pin_o = 2'b11, pin_oe_o = 2'b11).
- R2: A write with wr_en_i loads wr_data_i into the control register on the next clock, and rd_data_o returns it. Bit 2 is reserved: writes to it are ignored and it always reads 0.
- R3: While awake, a high sleep_req_i moves the block to sleep, and awake_o falls on the next clock.
- R4: While asleep, an enabled source moves the block to wake, and awake_o rises on the next clock. The enable bits map as follows: bit 6 enables transient (evt_i[3]), bit 5 orientation (evt_i[2]), bit 4 pulse (evt_i[1]) and bit 3 freefall/motion (evt_i[0]).
- R5: While asleep, a source whose enable bit is 0 neither wakes the block nor reaches a pin.
- R6: While awake, every source reaches its pin regardless of the enable bits.
- R7: With the default route, pin 0 carries transient and pulse, and pin 1 carries orientation and freefall/motion. In each case it is the OR of the passed sources.
- R8: Control bit 1 selects the asserted level. At 0 an asserted pin drives 0 and an idle pin drives 1. At 1 the levels are the other way round.
- R9: Control bit 0 set to 1 selects open drain. pin_oe_o for a pin is 1 only while that pin is asserted, and pin_o then holds the asserted level. With bit 0 at 0, pin_oe_o is always 1.
- R10: While asleep, sleep_req_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| sleep_req_i | input | 1 | Sleep request from inactivity timer |
| evt_i | input | 4 | Events: [3] transient, [2] orientation, [1] pulse, [0] freefall/motion |
| awake_o | output | 1 | 1 = wake state, 0 = sleep state |
| pin_o | output | 2 | Interrupt pin levels |
| pin_oe_o | output | 2 | Interrupt pin output enables |

## Verification
The assertions assume that the event inputs and the sleep request are synchronous to clk_i, and that each stays stable for a whole cycle. Under that assumption, the next state follows from the current state, the request and the enabled events sampled at one edge. The bench changes every input only on the falling edge. It samples the registered state one falling edge after the rising edge that updates it, and it checks the combinational pin outputs shortly after each input change.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned REG_W   = 8;

  typedef struct packed {
    logic               spare;
    logic [NUM_SRC-1:0] wake_en;
    logic               rsvd;
    logic               pol_hi;
    logic               open_drn;
  } ctrl_t;
endpackage

// File: rtl/swk_ctrl_reg.sv
module swk_ctrl_reg
  import swk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o
);
  ctrl_t wr_val;

  always_comb begin
    wr_val      = ctrl_t'(wr_data_i);
    wr_val.rsvd = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_o <= '0;
    else if (wr_en_i) ctrl_o <= wr_val;
  end
endmodule

// File: rtl/swk_state.sv
module swk_state
  import swk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] wake_en_i,
  output logic               awake_o,
  output logic [NUM_SRC-1:0] pass_o
);
  logic wake_hit;

  assign pass_o   = awake_o ? evt_i : (evt_i & wake_en_i);
  assign wake_hit = |(evt_i & wake_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   awake_o <= 1'b1;
    else if (awake_o)              awake_o <= ~sleep_req_i;
    else if (wake_hit)             awake_o <= 1'b1;
  end
endmodule

// File: rtl/swk_pin_drv.sv
module swk_pin_drv (
  input  logic asserted_i,
  input  logic pol_hi_i,
  input  logic open_drn_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    if (open_drn_i) begin
      pin_o = pol_hi_i;
      oe_o  = asserted_i;
    end else begin
      pin_o = asserted_i ~^ pol_hi_i;
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/sleep_wake_irq_ctrl.sv
module sleep_wake_irq_ctrl
  import swk_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter logic [NUM_PINS*NUM_SRC-1:0] PIN_ROUTE = 8'b0101_1010
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                sleep_req_i,
  input  logic [NUM_SRC-1:0]  evt_i,
  output logic                awake_o,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  ctrl_t              ctrl;
  logic [NUM_SRC-1:0] pass;

  swk_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ctrl_o(ctrl)
  );

  swk_state u_state (
    .clk_i, .rst_ni, .sleep_req_i, .evt_i,
    .wake_en_i(ctrl.wake_en), .awake_o, .pass_o(pass)
  );

  assign rd_data_o = ctrl;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = |(pass & PIN_ROUTE[p*NUM_SRC +: NUM_SRC]);
    swk_pin_drv u_drv (
      .asserted_i(hit), .pol_hi_i(ctrl.pol_hi), .open_drn_i(ctrl.open_drn),
      .pin_o(pin_o[p]), .oe_o(pin_oe_o[p])
    );
  end
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
  parameter int unsigned NUM_PINS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          rd_data_o,
  input logic                sleep_req_i,
  input logic [3:0]          evt_i,
  input logic                awake_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2] == 1'b0);
  // R3
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o && sleep_req_i |=> !awake_o);
  // R4
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o && |(evt_i & rd_data_o[6:3]) |=> awake_o);
  // R5
  stay_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o && !(|(evt_i & rd_data_o[6:3])) |=> !awake_o);
  // R9
  od_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] |-> (pin_o == {NUM_PINS{rd_data_o[1]}}));
  // R9
  pp_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> (pin_oe_o == {NUM_PINS{1'b1}}));
endmodule

bind sleep_wake_irq_ctrl swk_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i, .rst_ni, .rd_data_o, .sleep_req_i, .evt_i, .awake_o, .pin_o, .pin_oe_o
);

// File: tb/sim_sleep_wake_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, sleep_req = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] evt = 0;
  logic [7:0] rd_data;
  logic       awake;
  logic [1:0] pin, pin_oe;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .sleep_req_i(sleep_req), .evt_i(evt),
    .awake_o(awake), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go_sleep();
    @(negedge clk); evt = 0; sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", rd_data, 8'h00);
    chk("R1 awake", {7'd0, awake}, 8'd1);
    chk("R1 pin", {6'd0, pin}, 8'h03);
    chk("R1 oe", {6'd0, pin_oe}, 8'h03);
  endtask

  task automatic t_reg();
    wr(8'hFF); chk("R2 ff", rd_data, 8'hFB);
    wr(8'h04); chk("R2 rsvd", rd_data, 8'h00);
    wr(8'hA5); chk("R2 a5", rd_data, 8'hA1);
    wr(8'h00); chk("R2 zero", rd_data, 8'h00);
  endtask

  task automatic t_sleep();
    go_sleep(); chk("R3 sleep", {7'd0, awake}, 8'd0);
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    chk("R10 req in sleep", {7'd0, awake}, 8'd0);
  endtask

  task automatic t_disabled();
    wr(8'h10);
    @(negedge clk); evt = 4'b1101; #1;
    chk("R5 pins", {6'd0, pin}, 8'h03);
    @(negedge clk); chk("R5 no wake", {7'd0, awake}, 8'd0);
    evt = 4'b0010; #1;
    chk("R4 pulse pin0", {6'd0, pin}, 8'h02);
    @(negedge clk); evt = 0;
    chk("R4 pulse wake", {7'd0, awake}, 8'd1);
  endtask

  task automatic t_each_src();
    for (int i = 0; i < 4; i++) begin
      wr(8'h08 << i);
      go_sleep();
      @(negedge clk); evt = 4'b0001 << i;
      @(negedge clk); evt = 0;
      chk($sformatf("R4 src %0d", i), {7'd0, awake}, 8'd1);
    end
  endtask

  task automatic t_wake_pass();
    wr(8'h00);
    @(negedge clk); evt = 4'b1000; #1; chk("R6 R7 transient", {6'd0, pin}, 8'h02);
    evt = 4'b0100; #1; chk("R6 R7 orient", {6'd0, pin}, 8'h01);
    evt = 4'b0001; #1; chk("R7 ffmt", {6'd0, pin}, 8'h01);
    evt = 4'b1111; #1; chk("R6 all", {6'd0, pin}, 8'h00);
    evt = 0;
  endtask

  task automatic t_pol();
    wr(8'h02); #1; chk("R8 idle hi-pol", {6'd0, pin}, 8'h00);
    evt = 4'b0100; #1; chk("R8 asserted hi-pol", {6'd0, pin}, 8'h02);
    evt = 0;
  endtask

  task automatic t_od();
    wr(8'h01); #1; chk("R9 od idle oe", {6'd0, pin_oe}, 8'h00);
    evt = 4'b0010; #1;
    chk("R9 od oe", {6'd0, pin_oe}, 8'h01);
    chk("R9 od lvl", {7'd0, pin[0]}, 8'h00);
    wr(8'h03); #1;
    chk("R9 od hi lvl", {7'd0, pin[0]}, 8'h01);
    chk("R9 od hi oe", {6'd0, pin_oe}, 8'h01);
    evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD*3 + 2);
    t_reset();
    rst_n = 1;
    t_reg(); t_sleep(); t_disabled(); t_each_src(); t_wake_pass(); t_pol(); t_od();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule